// File: doc/BRIEF.md
# Byte-Wide Arithmetic and Logic Unit with Zero and Carry Flags

This block computes one 8-bit data operation per clock for a small processor that has no accumulator. The first operand comes from the destination register. The second operand is either another register or an 8-bit immediate. The block returns the result, the next values of the ZERO and CARRY flags, and a write-enable that tells the register file whether the destination register takes the result.

Outputs are registered, so results appear one clock after the operands. The register file, the instruction decoder and the flag storage sit outside the block. The decoder drives a 5-bit operation code. The flag storage feeds back the current ZERO and CARRY values and stores `zero_o` and `carry_o` every cycle.

The block has no state machine. Its only sequential state is the output register stage (`s_result`, `s_zero`, `s_carry`, `s_wr`). It moves from its reset state to computing state on the first clock after `rst_n` goes high, and it keeps computing on every later edge.

Top module: `alu8_core`

## Requirements
- R1: The operation codes are 0 ADD, 1 ADDC, 2 SUB, 3 SUBC, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 TEST, 9 LOAD, 10 SL0, 11 SL1, 12 SLX, 13 SLA, 14 SR0, 15 SR1, 16 SRX, 17 SRA, 18 RL and 19 RR. When `imm_sel_i`=1 the second operand is `imm_i`; otherwise it is `reg_b_i`. Codes 20 to 31 give result 0 and write-enable 0, and they pass both flag inputs through unchanged.
- R2: ADD gives a+b. ADDC gives a+b+carry_i. For both, CARRY is the carry out of bit 7.
- R3: SUB gives a-b. SUBC gives a-b-carry_i. For both, the result is modulo 256 and CARRY is 1 when the true difference is negative.
- R4: AND, OR and XOR produce the bitwise result and always clear CARRY.
- R5: CMP drives write-enable to 0. It sets ZERO when a equals b and sets CARRY when a is less than b (unsigned). The result output shows a-b modulo 256.
- R6: TEST drives write-enable to 0. The result output shows a AND b. ZERO is set when that value is 0, and CARRY is the XOR of all of its bits (odd parity).
- R7: LOAD gives result b and write-enable 1. ZERO and CARRY take the values of `zero_i` and `carry_i`.
- R8: The left shifts give {a[6:0],fill} with CARRY=a[7]. The fill bit is 0 for SL0, 1 for SL1, a[0] for SLX and carry_i for SLA.
- R9: The right shifts give {fill,a[7:1]} with CARRY=a[0]. The fill bit is 0 for SR0, 1 for SR1, a[7] for SRX and carry_i for SRA.
- R10: RL gives {a[6:0],a[7]} with CARRY=a[7]. RR gives {a[0],a[7:1]} with CARRY=a[0].
- R11: For every operation except LOAD and codes 20 to 31, ZERO is 1 exactly when the 8-bit result is 0. Write-enable is 1 for codes 0 to 3, 5 to 7 and 9 to 19.
- R12: All outputs are registered and appear one clock after the inputs. While `rst_n` is low every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| imm_sel_i | input | 1 | 1 selects the immediate as the second operand |
| reg_a_i | input | 8 | First operand (destination register value) |
| reg_b_i | input | 8 | Second register operand |
| imm_i | input | 8 | Immediate operand |
| carry_i | input | 1 | Current CARRY flag |
| zero_i | input | 1 | Current ZERO flag |
| result_o | output | 8 | Result |
| zero_o | output | 1 | Next ZERO flag |
| carry_o | output | 1 | Next CARRY flag |
| wr_o | output | 1 | Destination register write-enable |

## Verification
The assertions assume that every input is a known value at each rising edge. They also take the previous cycle's inputs as the source of the current registered outputs. For that reason they are disabled during reset and during the first edge after reset. The stimulus changes inputs only on falling edges and keeps `op_i` mostly within the defined codes 0 to 19. Undefined codes are applied only in a directed group. Random operands are mixed with directed corners: equal operands, carry and borrow across bit 7, zero results, and all-ones and all-zero operands for every shift fill.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC = 5'd3,
        OP_CMP  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
        OP_TEST = 5'd8,  OP_LOAD = 5'd9,  OP_SL0  = 5'd10, OP_SL1  = 5'd11,
        OP_SLX  = 5'd12, OP_SLA  = 5'd13, OP_SR0  = 5'd14, OP_SR1  = 5'd15,
        OP_SRX  = 5'd16, OP_SRA  = 5'd17, OP_RL   = 5'd18, OP_RR   = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_SHIFT = 2'd2,
        CLS_NONE  = 2'd3
    } op_class_e;

    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        if (op <= 5'd4)       return CLS_ARITH;
        else if (op <= 5'd9)  return CLS_LOGIC;
        else if (op <= 5'd19) return CLS_SHIFT;
        else                  return CLS_NONE;
    endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    localparam int EXT_W = W + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] dif_ext;
    logic             use_cin;

    always_comb begin
        use_cin = (op == OP_ADDC) || (op == OP_SUBC);
        sum_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, use_cin & cin};
        dif_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, use_cin & cin};
        if (op == OP_ADD || op == OP_ADDC) begin
            res  = sum_ext[W-1:0];
            cout = sum_ext[W];
        end else begin
            res  = dif_ext[W-1:0];
            cout = dif_ext[W];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    always_comb begin
        res  = '0;
        cout = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_TEST: begin
                res  = a & b;
                cout = ^(a & b);
            end
            OP_LOAD: begin
                res  = b;
                cout = cin;
            end
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);
    logic fill;
    logic go_left;

    always_comb begin
        go_left = (op >= OP_SL0 && op <= OP_SLA) || (op == OP_RL);
        unique case (op)
            OP_SL0, OP_SR0: fill = 1'b0;
            OP_SL1, OP_SR1: fill = 1'b1;
            OP_SLX:         fill = a[0];
            OP_SRX:         fill = a[W-1];
            OP_SLA, OP_SRA: fill = cin;
            OP_RL:          fill = a[W-1];
            OP_RR:          fill = a[0];
            default:        fill = 1'b0;
        endcase
        if (go_left) begin
            res  = {a[W-2:0], fill};
            cout = a[W-1];
        end else begin
            res  = {fill, a[W-1:1]};
            cout = a[0];
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic            imm_sel_i,
    input  logic [W-1:0]    reg_a_i,
    input  logic [W-1:0]    reg_b_i,
    input  logic [W-1:0]    imm_i,
    input  logic            carry_i,
    input  logic            zero_i,
    output logic [W-1:0]    result_o,
    output logic            zero_o,
    output logic            carry_o,
    output logic            wr_o
);
    logic [W-1:0] opnd_b;
    logic [W-1:0] ar_res, lg_res, sh_res;
    logic         ar_c, lg_c, sh_c;
    logic [W-1:0] nx_res;
    logic         nx_z, nx_c, nx_wr;
    op_class_e    cls;

    logic [W-1:0] s_result;
    logic         s_zero, s_carry, s_wr;
    logic         live_q;

    assign opnd_b = imm_sel_i ? imm_i : reg_b_i;
    assign cls    = classify(op_i);

    alu8_arith #(.W(W)) u_arith (
        .op(op_i), .a(reg_a_i), .b(opnd_b), .cin(carry_i),
        .res(ar_res), .cout(ar_c)
    );
    alu8_logic #(.W(W)) u_logic (
        .op(op_i), .a(reg_a_i), .b(opnd_b), .cin(carry_i),
        .res(lg_res), .cout(lg_c)
    );
    alu8_shift #(.W(W)) u_shift (
        .op(op_i), .a(reg_a_i), .cin(carry_i),
        .res(sh_res), .cout(sh_c)
    );

    always_comb begin
        nx_res = '0;
        nx_c   = carry_i;
        nx_z   = zero_i;
        nx_wr  = 1'b0;
        unique case (cls)
            CLS_ARITH: begin
                nx_res = ar_res;
                nx_c   = ar_c;
                nx_z   = (ar_res == '0);
                nx_wr  = (op_i != OP_CMP);
            end
            CLS_LOGIC: begin
                nx_res = lg_res;
                nx_c   = lg_c;
                nx_z   = (op_i == OP_LOAD) ? zero_i : (lg_res == '0);
                nx_wr  = (op_i != OP_TEST);
            end
            CLS_SHIFT: begin
                nx_res = sh_res;
                nx_c   = sh_c;
                nx_z   = (sh_res == '0);
                nx_wr  = 1'b1;
            end
            CLS_NONE: begin
                nx_res = '0;
                nx_c   = carry_i;
                nx_z   = zero_i;
                nx_wr  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_result <= '0;
            s_zero   <= 1'b0;
            s_carry  <= 1'b0;
            s_wr     <= 1'b0;
            live_q   <= 1'b0;
        end else begin
            s_result <= nx_res;
            s_zero   <= nx_z;
            s_carry  <= nx_c;
            s_wr     <= nx_wr;
            live_q   <= 1'b1;
        end
    end

    assign result_o = s_result;
    assign zero_o   = s_zero;
    assign carry_o  = s_carry;
    assign wr_o     = s_wr;

    assert_logic_clears_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) inside {OP_AND, OP_OR, OP_XOR}) |-> !carry_o);

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) == OP_CMP) |-> !wr_o && (zero_o == ($past(reg_a_i) == $past(opnd_b))));

    assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) == OP_TEST) |-> !wr_o && (carry_o == ^result_o));

    assert_load_holds_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) == OP_LOAD) |-> zero_o == $past(zero_i) && carry_o == $past(carry_i));

    assert_rotate_keeps_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) inside {OP_RL, OP_RR}) |-> $countones(result_o) == $countones($past(reg_a_i)));

    assert_zero_tracks_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        live_q && ($past(op_i) < 5'd20) && ($past(op_i) != OP_LOAD) |-> zero_o == (result_o == '0));

    assert_reset_clears_R12: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && live_q == 1'b0 |-> result_o == '0 && !wr_o && !zero_o && !carry_o);
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] op_i = '0;
    logic       imm_sel_i = 1'b0;
    logic [7:0] reg_a_i = '0, reg_b_i = '0, imm_i = '0;
    logic       carry_i = 1'b0, zero_i = 1'b0;
    logic [7:0] result_o;
    logic       zero_o, carry_o, wr_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .imm_sel_i(imm_sel_i),
        .reg_a_i(reg_a_i), .reg_b_i(reg_b_i), .imm_i(imm_i),
        .carry_i(carry_i), .zero_i(zero_i),
        .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o), .wr_o(wr_o)
    );

    // returns {wr, zero, carry, result}
    function automatic logic [10:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic c, input logic z);
        logic [8:0] t;
        logic [7:0] r;
        logic       nc, nz, w;
        r = '0; nc = c; nz = z; w = 1'b1;
        case (op)
            5'd0:  begin t = a + b;           r = t[7:0]; nc = t[8]; end
            5'd1:  begin t = a + b + c;       r = t[7:0]; nc = t[8]; end
            5'd2:  begin t = {1'b0,a} - b;     r = t[7:0]; nc = (a < b); end
            5'd3:  begin t = {1'b0,a} - b - c; r = t[7:0]; nc = ({1'b0,a} < ({1'b0,b} + c)); end
            5'd4:  begin r = a - b; nc = (a < b); w = 1'b0; end
            5'd5:  begin r = a & b; nc = 1'b0; end
            5'd6:  begin r = a | b; nc = 1'b0; end
            5'd7:  begin r = a ^ b; nc = 1'b0; end
            5'd8:  begin r = a & b; nc = ^(a & b); w = 1'b0; end
            5'd9:  r = b;
            5'd10: begin r = {a[6:0], 1'b0}; nc = a[7]; end
            5'd11: begin r = {a[6:0], 1'b1}; nc = a[7]; end
            5'd12: begin r = {a[6:0], a[0]}; nc = a[7]; end
            5'd13: begin r = {a[6:0], c};    nc = a[7]; end
            5'd14: begin r = {1'b0, a[7:1]}; nc = a[0]; end
            5'd15: begin r = {1'b1, a[7:1]}; nc = a[0]; end
            5'd16: begin r = {a[7], a[7:1]}; nc = a[0]; end
            5'd17: begin r = {c, a[7:1]};    nc = a[0]; end
            5'd18: begin r = {a[6:0], a[7]}; nc = a[7]; end
            5'd19: begin r = {a[0], a[7:1]}; nc = a[0]; end
            default: begin r = '0; w = 1'b0; end
        endcase
        if (op < 5'd20 && op != 5'd9) nz = (r == 8'd0);
        return {w, nz, nc, r};
    endfunction

    function automatic string req_of(input logic [4:0] op);
        if (op <= 5'd1)       return "R2";
        else if (op <= 5'd3)  return "R3";
        else if (op == 5'd4)  return "R5";
        else if (op <= 5'd7)  return "R4";
        else if (op == 5'd8)  return "R6";
        else if (op == 5'd9)  return "R7";
        else if (op <= 5'd13) return "R8";
        else if (op <= 5'd17) return "R9";
        else if (op <= 5'd19) return "R10";
        else                  return "R1";
    endfunction

    task automatic apply(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] k, input logic sel, input logic c, input logic z);
        logic [10:0] exp_v;
        @(negedge clk);
        op_i = op; reg_a_i = a; reg_b_i = b; imm_i = k; imm_sel_i = sel;
        carry_i = c; zero_i = z;
        exp_v = model(op, a, sel ? k : b, c, z);
        @(posedge clk);
        #1;
        n_vec++;
        if ({wr_o, zero_o, carry_o, result_o} !== exp_v) begin
            n_bad++;
            $display("FAIL %s (R11) op=%0d a=%h b=%h k=%h sel=%b: got wr/z/c/res=%b/%b/%b/%h expected %b/%b/%b/%h",
                     req_of(op), op, a, b, k, sel, wr_o, zero_o, carry_o, result_o,
                     exp_v[10], exp_v[9], exp_v[8], exp_v[7:0]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        n_vec++;
        if ({wr_o, zero_o, carry_o, result_o} !== 11'd0) begin
            n_bad++;
            $display("FAIL R12 reset outputs: got %h expected 000", {wr_o, zero_o, carry_o, result_o});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R2 carry out of bit 7, ADDC adds carry
        apply(5'd0, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0);
        apply(5'd1, 8'h7F, 8'h80, 8'h00, 1'b0, 1'b1, 1'b0);
        // R3 borrow, SUBC with borrow in
        apply(5'd2, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
        apply(5'd3, 8'h05, 8'h05, 8'h00, 1'b0, 1'b1, 1'b0);
        apply(5'd3, 8'h05, 8'h04, 8'h00, 1'b0, 1'b1, 1'b0);
        // R5 compare equal / less / greater, R1 immediate select
        apply(5'd4, 8'h3C, 8'h00, 8'h3C, 1'b1, 1'b1, 1'b0);
        apply(5'd4, 8'h10, 8'h11, 8'h00, 1'b0, 1'b0, 1'b1);
        apply(5'd4, 8'h90, 8'h11, 8'h00, 1'b0, 1'b1, 1'b1);
        // R4 logic clears carry
        apply(5'd5, 8'hF0, 8'h0F, 8'h00, 1'b0, 1'b1, 1'b0);
        apply(5'd7, 8'hAA, 8'h00, 8'h55, 1'b1, 1'b1, 1'b0);
        // R6 test parity
        apply(5'd8, 8'h07, 8'h03, 8'h00, 1'b0, 1'b0, 1'b1);
        apply(5'd8, 8'h07, 8'h01, 8'h00, 1'b0, 1'b0, 1'b1);
        // R7 load holds flags
        apply(5'd9, 8'h12, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
        apply(5'd9, 8'h12, 8'h00, 8'hAB, 1'b1, 1'b0, 1'b0);
        // R8 R9 R10 fill variants on all-zeros and all-ones
        for (int op = 10; op <= 19; op++) begin
            apply(5'(op), 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
            apply(5'(op), 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
            apply(5'(op), 8'h81, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1);
        end
        // R1 undefined codes
        for (int op = 20; op <= 31; op++)
            apply(5'(op), 8'h5A, 8'hA5, 8'h00, 1'b0, op[0], op[1]);
        // random
        for (int i = 0; i < 3000; i++) begin
            apply(5'($urandom_range(19, 0)), 8'($urandom), 8'($urandom), 8'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
        end
        // R12 reset again clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        n_vec++;
        if ({wr_o, zero_o, carry_o, result_o} !== 11'd0) begin
            n_bad++;
            $display("FAIL R12 reasserted reset: got %h expected 000", {wr_o, zero_o, carry_o, result_o});
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule